// File: doc/BRIEF.md
# Integer ALU with Immediate Operands

This block is the purely combinational integer unit of a simple register-to-register processor core. Each cycle it receives two 32-bit register values, a 16-bit immediate field, an operation code and an immediate-select flag. It returns a 32-bit result and a signed-overflow flag, and nothing in it holds state.

When the immediate-select flag is set, the immediate replaces the second register operand. The immediate is widened in one of two ways. Arithmetic operations and compare operations copy its top bit into the upper half. Bitwise operations fill the upper half with zeros. One case needs care: the unsigned compare with an immediate still copies the sign bit into the upper half, and the comparison that follows treats both operands as unsigned. Add and subtract come in a trapping (signed) form and a non-trapping (unsigned) form. The two forms produce the same result bits. Only the trapping forms can raise the overflow flag, which the surrounding pipeline uses to start an exception.

Top module: `int_alu_imm`

## Requirements
- R1: Operation codes on `op_sel` are 0 = ADD, 1 = ADDU, 2 = SUB, 3 = SUBU, 4 = SLT, 5 = SLTU, 6 = AND, 7 = OR, 8 = XOR, 9 = NOR. ADD and ADDU both return (A + B) mod 2^32 and give the same result bits for the same operands.
- R2: ADD raises `ovf` exactly when the true signed sum of A and B lies outside the range -2^31 to 2^31-1.
- R3: SUB and SUBU both return (A - B) mod 2^32. SUB raises `ovf` exactly when the true signed difference lies outside the range -2^31 to 2^31-1.
- R4: ADDU and SUBU never raise `ovf`, for any operands.
- R5: When `use_imm` = 1 and the operation is one of codes 0 to 5, the second operand is `imm16` with bit 15 copied into bits 31:16.
- R6: SLT returns 1 when A is less than B as two's-complement values, and 0 otherwise. Bits 31:1 of the result are always 0.
- R7: SLTU returns 1 when A is less than B as unsigned values, and 0 otherwise. With `use_imm` = 1, the immediate is first sign-extended as in R5 and then compared unsigned.
- R8: AND, OR, XOR and NOR operate bit by bit. When `use_imm` = 1 for these codes, the second operand is `imm16` with bits 31:16 set to zero.
- R9: Codes 10 to 15 return a result of 0 with `ovf` = 0.
- R10: When `use_imm` = 0, the value of `imm16` has no effect on either output. When `use_imm` = 1, the value of `src_b` has no effect on either output.
- R11: SLT, SLTU, AND, OR, XOR and NOR never raise `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| use_imm | input | 1 | 1 selects the widened immediate as the second operand |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of ADD or SUB |

## Verification
The bench targets the operand values where the overflow flag changes: 0x7FFFFFFF + 1, 0x80000000 - 1, and sums that land just inside the signed range. If the overflow logic were wrong, the flag would be missing on these cases or would appear on ADDU and SUBU. A second target is the unsigned compare against an immediate of 0x8000 or above. A design that zero-extended that immediate would compare against a small positive number and return the opposite answer for large A. The bench also checks that the logical immediates 0x8000 and 0xFFFF leave the upper half clear. A sign-extending design would set bits 31:16 after OR and keep them after AND. Finally, it checks that the unused operand input is ignored and that the undefined codes return zero.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_SLT  = 4'd4,
    OP_SLTU = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOR  = 4'd9
  } alu_op_e;

  function automatic logic op_is_bitwise(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm,
  input  logic              zero_ext,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int FILL_W = DATA_W - IMM_W;

  logic [FILL_W-1:0] fill;
  logic [DATA_W-1:0] imm_wide;

  always_comb begin
    fill     = zero_ext ? '0 : {FILL_W{imm[IMM_W-1]}};
    imm_wide = {fill, imm};
    opnd_b   = use_imm ? imm_wide : reg_b;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              do_sub,
  input  logic              chk_ovf,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              sign_mismatch;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    sum   = a + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
    // Overflow: operands (after inversion) share a sign that the sum lost.
    sign_mismatch = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    ovf = chk_ovf && sign_mismatch;
  end

  // R3: a subtraction of equal operands yields zero and never overflows
  always_comb begin
    if (do_sub && !$isunknown(a) && (a == b))
      assert_sub_self_zero_R3: assert (sum == '0 && !ovf);
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              is_signed,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              lt
);
  localparam int MSB = DATA_W - 1;

  logic ult;

  always_comb begin
    ult = a < b;
    // Differing signs flip the unsigned verdict for a signed compare.
    lt  = (is_signed && (a[MSB] != b[MSB])) ? a[MSB] : ult;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_alu_imm.sv
module int_alu_imm
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm16,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  logic              bitwise;
  logic              do_sub;
  logic              chk_ovf;
  logic              cmp_signed;
  logic [1:0]        logic_fn;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic              as_ovf;
  logic              lt;
  logic [DATA_W-1:0] lgc_y;

  always_comb begin
    bitwise    = op_is_bitwise(op_sel);
    do_sub     = (op_sel == OP_SUB) || (op_sel == OP_SUBU);
    chk_ovf    = (op_sel == OP_ADD) || (op_sel == OP_SUB);
    cmp_signed = (op_sel == OP_SLT);
    logic_fn   = 2'(op_sel - OP_AND);
  end

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .use_imm  (use_imm),
    .zero_ext (bitwise),
    .reg_b    (src_b),
    .imm      (imm16),
    .opnd_b   (opnd_b)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .do_sub  (do_sub),
    .chk_ovf (chk_ovf),
    .a       (src_a),
    .b       (opnd_b),
    .sum     (sum),
    .ovf     (as_ovf)
  );

  alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .is_signed (cmp_signed),
    .a         (src_a),
    .b         (opnd_b),
    .lt        (lt)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .fn (logic_fn),
    .a  (src_a),
    .b  (opnd_b),
    .y  (lgc_y)
  );

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: begin
        result = sum;
        ovf    = as_ovf;
      end
      OP_SLT, OP_SLTU: result = {{(DATA_W-1){1'b0}}, lt};
      OP_AND, OP_OR, OP_XOR, OP_NOR: result = lgc_y;
      default: result = '0;
    endcase
  end

  // Assertions next to the output mux
  always_comb begin
    if (!$isunknown({op_sel, use_imm, src_a, src_b, imm16})) begin
      // R4 / R11: only the trapping add and subtract may flag overflow
      assert_no_overflow_R4: assert (!ovf || op_sel == OP_ADD || op_sel == OP_SUB);
      // R6: a compare returns a single bit
      if (op_sel == OP_SLT || op_sel == OP_SLTU)
        assert_cmp_onebit_R6: assert (result[DATA_W-1:1] == '0);
      // R8: AND with a zero-extended immediate clears the upper half
      if (use_imm && op_sel == OP_AND)
        assert_andi_upper_R8: assert (result[DATA_W-1:IMM_W] == '0);
      // R8: OR with an immediate sets every immediate bit
      if (use_imm && op_sel == OP_OR)
        assert_ori_bits_R8: assert ((result[IMM_W-1:0] & imm16) == imm16);
      // R9: undefined codes give zero
      if (op_sel > OP_NOR)
        assert_undef_zero_R9: assert (result == '0 && !ovf);
    end
  end
endmodule

// File: tb/sim_int_alu_imm.sv
module sim_int_alu_imm;
  localparam time HALF = 10ns;

  logic        clk;
  logic [3:0]  op_sel;
  logic        use_imm;
  logic [31:0] src_a, src_b;
  logic [15:0] imm16;
  logic [31:0] result;
  logic        ovf;

  int n_tests = 0;
  int n_fail  = 0;

  int_alu_imm u0 (
    .op_sel  (op_sel),
    .use_imm (use_imm),
    .src_a   (src_a),
    .src_b   (src_b),
    .imm16   (imm16),
    .result  (result),
    .ovf     (ovf)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  // Reference model built from the requirements
  function automatic logic [31:0] ref_opb(input logic [3:0] op, input logic ui,
                                          input logic [31:0] b, input logic [15:0] im);
    if (!ui) return b;
    if (op >= 4'd6 && op <= 4'd9) return {16'h0000, im};
    return {{16{im[15]}}, im};
  endfunction

  function automatic logic [32:0] ref_model(input logic [3:0] op, input logic ui,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [15:0] im);
    logic [31:0] bb;
    longint sa, sb, full;
    logic [31:0] r;
    logic o;
    bb = ref_opb(op, ui, b, im);
    sa = longint'($signed(a));
    sb = longint'($signed(bb));
    o  = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        r = a + bb; full = sa + sb;
        o = (op == 4'd0) && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      4'd2, 4'd3: begin
        r = a - bb; full = sa - sb;
        o = (op == 4'd2) && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      4'd4: r = (sa < sb) ? 32'd1 : 32'd0;
      4'd5: r = (a < bb) ? 32'd1 : 32'd0;
      4'd6: r = a & bb;
      4'd7: r = a | bb;
      4'd8: r = a ^ bb;
      4'd9: r = ~(a | bb);
      default: r = 32'd0;
    endcase
    return {o, r};
  endfunction

  function automatic string req_of(input logic [3:0] op, input logic ui);
    case (op)
      4'd0, 4'd1: return ui ? "R1/R5" : "R1";
      4'd2, 4'd3: return "R3";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7, 4'd8, 4'd9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d imm=%0b got ovf=%0b res=%h expected ovf=%0b res=%h",
               req, op_sel, use_imm, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  // Drive at posedge, sample at negedge
  task automatic apply(input logic [3:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input string req);
    @(posedge clk);
    op_sel = op; use_imm = ui; src_a = a; src_b = b; imm16 = im;
    @(negedge clk);
    check(req, {ovf, result}, ref_model(op, ui, a, b, im));
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [32:0] first;
    void'($urandom(32'd4711));
    op_sel = 4'd15; use_imm = 1'b0; src_a = '0; src_b = '0; imm16 = '0;
    @(negedge clk);
    check("R9 idle", {ovf, result}, 33'd0);

    // R2 overflow edges
    apply(4'd0, 0, 32'h7FFFFFFF, 32'h00000001, 16'h0, "R2 max+1");
    apply(4'd0, 0, 32'h80000000, 32'hFFFFFFFF, 16'h0, "R2 min-1 via add");
    apply(4'd0, 0, 32'h7FFFFFFE, 32'h00000001, 16'h0, "R2 no ovf edge");
    apply(4'd0, 1, 32'h80000000, 32'h0, 16'hFFFF, "R2/R5 addi -1");
    // R3 subtraction edges
    apply(4'd2, 0, 32'h80000000, 32'h00000001, 16'h0, "R3 min-1");
    apply(4'd2, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, "R3 max-(-1)");
    apply(4'd2, 0, 32'h00000000, 32'h80000000, 16'h0, "R3 0-min");
    // R4 unsigned forms never flag
    apply(4'd1, 0, 32'h7FFFFFFF, 32'h00000001, 16'h0, "R4 addu");
    apply(4'd3, 0, 32'h80000000, 32'h00000001, 16'h0, "R4 subu");
    // R6 / R7 compares
    apply(4'd4, 0, 32'hFFFFFFFF, 32'h00000000, 16'h0, "R6 -1<0");
    apply(4'd5, 0, 32'hFFFFFFFF, 32'h00000000, 16'h0, "R7 big<0 false");
    apply(4'd5, 1, 32'hFFFFFFFE, 32'h0, 16'hFFFF, "R7 sltiu sext");
    apply(4'd5, 1, 32'h00009000, 32'h0, 16'h8000, "R7 sltiu 0x8000");
    apply(4'd4, 1, 32'h00000000, 32'h0, 16'h8000, "R6/R5 slti neg");
    // R8 zero-extended logical immediates
    apply(4'd6, 1, 32'hFFFFFFFF, 32'h0, 16'h8000, "R8 andi");
    apply(4'd7, 1, 32'h00000000, 32'h0, 16'hFFFF, "R8 ori");
    apply(4'd8, 1, 32'h12345678, 32'h0, 16'hF0F0, "R8 xori");
    apply(4'd9, 1, 32'h00000000, 32'h0, 16'h8001, "R8 nor imm");
    // R11 no overflow from compare / logic on extreme operands
    apply(4'd4, 0, 32'h7FFFFFFF, 32'h80000000, 16'h0, "R11 slt");
    apply(4'd7, 0, 32'h7FFFFFFF, 32'h80000000, 16'h0, "R11 or");
    // R9 undefined codes
    for (int c = 10; c < 16; c++)
      apply(4'(c), 0, 32'hFFFFFFFF, 32'h7FFFFFFF, 16'hFFFF, "R9 undefined");

    // R10: unused input ignored
    apply(4'd0, 0, 32'h7FFFFFFF, 32'h1, 16'h0000, "R10 base");
    first = {ovf, result};
    @(posedge clk); imm16 = 16'hFFFF;
    @(negedge clk); check("R10 imm ignored", {ovf, result}, first);
    apply(4'd7, 1, 32'h0, 32'h0, 16'h00FF, "R10 base imm");
    first = {ovf, result};
    @(posedge clk); src_b = 32'hFFFFFFFF;
    @(negedge clk); check("R10 src_b ignored", {ovf, result}, first);

    // R1 ADD and ADDU agree on result bits
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      logic [31:0] r_signed;
      a = $urandom; b = $urandom;
      apply(4'd0, 0, a, b, 16'h0, "R1 add");
      r_signed = result;
      apply(4'd1, 0, a, b, 16'h0, "R1 addu");
      check("R1 add==addu", {1'b0, result}, {1'b0, r_signed});
    end

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  op;
      logic        ui;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 11));
      ui = 1'($urandom);
      a  = $urandom; b = $urandom;
      if (i % 4 == 0) a = {$urandom_range(0, 1) == 0 ? 2'b01 : 2'b10, 30'($urandom)};
      apply(op, ui, a, b, 16'($urandom), req_of(op, ui));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule